// File: doc/BRIEF.md
# Buffered Serial Transmitter with Optional Ninth Bit

This block sends bytes on an asynchronous serial line. A single write port acts as the transmit buffer: a write while the block is idle captures the byte and the frame settings of that moment and starts a frame. The frame consists of a low start bit, eight data bits sent least significant bit first, an optional ninth bit, and one or two high stop bits. The ninth bit can carry parity or a multiprocessor address flag.

Bit timing comes either from an external baud tick or from an internal free-running divider of the system clock (one bit per 32 or 64 clocks). The mode input selects the timing source and whether the ninth bit is sent. A sticky done flag tells software that the last stop bit has begun, and software clears it with a pulse. The receive side and the baud generator are separate blocks, so transmission runs independently of reception.

The controller has seven states. In IDLE the line is high and a write is accepted. SYNC holds the line high until the first bit tick, so that the start bit lasts a full period. START drives the line low. DATA sends the eight data bits. NINTH sends the ninth bit. STOP1 sends the first stop bit. STOP2 sends the second stop bit. The transitions are: IDLE->SYNC on a write; SYNC->START, START->DATA and NINTH->STOP1 on a tick; DATA->NINTH, or DATA->STOP1 when there is no ninth bit, on the tick that ends the eighth data bit; STOP1->STOP2, or STOP1->IDLE with one stop bit, on a tick; STOP2->IDLE on a tick.

Top module: `sbuf_uart_tx`

## Requirements
- R1: After reset, txd is 1, busy is 0 and done is 0, and txd is 1 whenever busy is 0.
- R2: A write while busy is 0 makes busy 1 from the next cycle. txd then stays 1 until the first bit tick. After that tick, txd is 0 for exactly one tick period (the start bit).
- R3: The eight data bits of the written byte follow the start bit, least significant bit first, each held for one tick period.
- R4: mode encoding: 2'b00 sends no ninth bit. 2'b01, 2'b10 and 2'b11 send a ninth bit after the data bits, equal to bit9_in as sampled at the write.
- R5: two_stop=0 gives one stop bit and two_stop=1 gives two (txd=1 for each). busy falls at the tick that ends the last stop bit.
- R6: In mode 2'b01 the bit tick is internal and baud_tick is ignored. A counter runs freely from reset, and a tick occurs in the cycle where the number of clocks since reset, taken modulo the divisor, equals divisor-1. The divisor is 64 when fix_div64=1 and 32 when fix_div64=0.
- R7: In modes 2'b00, 2'b10 and 2'b11, each cycle in which baud_tick is 1 ends the current bit, even when the tick spacing is irregular.
- R8: done becomes 1 in the cycle the last stop bit begins and stays 1 until a cycle with done_clr=1. A set and a clear in the same cycle leave done at 1.
- R9: A write while busy is 1 is ignored: the frame in progress and its line output are unchanged.
- R10: mode, bit9_in, two_stop and fix_div64 are sampled at the accepted write. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the transmit buffer |
| wr_data | input | 8 | Byte to send |
| baud_tick | input | 1 | External bit-rate tick, one cycle wide |
| mode | input | 2 | Frame mode: 00 8-bit, 01 9-bit fixed rate, 10/11 9-bit external tick |
| bit9_in | input | 1 | Value of the ninth bit |
| two_stop | input | 1 | 1 selects two stop bits |
| fix_div64 | input | 1 | Fixed-rate divisor: 1 gives 64, 0 gives 32 |
| done_clr | input | 1 | Clears the done flag |
| txd | output | 1 | Serial line output, idle high |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | Sticky flag: last stop bit has begun |

## Verification
The frame is tried with several bytes (alternating bits, bits in groups, all zeros, all ones), so that a reversed bit order or a stuck shift stage produces a visible line difference. Each mode is run with both stop counts and both ninth-bit values, which separates a missing or wrong ninth bit from a wrong stop count. External ticks come at regular and irregular spacing, and the fixed mode runs with ticks present on baud_tick, so a design that uses the wrong timing source drifts out of phase. Writes and setting changes in the middle of a frame, and a held done_clr during the last stop bit, exercise the ignore rules and the set-over-clear priority.

// File: rtl/sbtx_pkg.sv
package sbtx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_START,
        ST_DATA,
        ST_NINTH,
        ST_STOP1,
        ST_STOP2
    } tx_state_e;

    typedef enum logic [1:0] {
        MD_8VAR  = 2'b00,
        MD_9FIX  = 2'b01,
        MD_9VAR  = 2'b10,
        MD_9VARB = 2'b11
    } tx_mode_e;

    typedef struct packed {
        logic nine;
        logic fixed;
        logic two;
        logic bit9;
        logic slow;
    } frame_cfg_t;

endpackage

// File: rtl/sbtx_rate.sv
module sbtx_rate #(
    parameter int FIX_LOG2 = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic use_fixed,
    input  logic slow,
    input  logic ext_tick,
    output logic bit_tick
);
    localparam int CW = FIX_LOG2 + 1;

    logic [CW-1:0] cnt_q;
    logic          fix_tick;

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        if (slow) fix_tick = &cnt_q;
        else      fix_tick = &cnt_q[FIX_LOG2-1:0];
        bit_tick = use_fixed ? fix_tick : ext_tick;
    end

    // R6: the internal tick is never two cycles wide
    assert_fixed_tick_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fix_tick |=> !fix_tick);

endmodule

// File: rtl/sbtx_shreg.sv
module sbtx_shreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] din,
    output logic              lsb
);
    logic [DATA_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     sh_q <= '0;
        else if (load)  sh_q <= din;
        else if (shift) sh_q <= {1'b0, sh_q[DATA_W-1:1]};
    end

    assign lsb = sh_q[0];

    // R3: zeros are shifted in from the top as bits leave at the bottom
    assert_shift_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> !sh_q[DATA_W-1]);

endmodule

// File: rtl/sbtx_fsm.sv
module sbtx_fsm
    import sbtx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       bit_tick,
    input  frame_cfg_t cfg,
    input  logic       lsb,
    input  logic       done_clr,
    output logic       load,
    output logic       shift,
    output logic       txd,
    output logic       busy,
    output logic       done
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    tx_state_e        state_q, state_d;
    logic [CNT_W-1:0] bitcnt_q;
    logic             done_q;
    logic             enter_last;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (wr_en)    state_d = ST_SYNC;
            ST_SYNC:  if (bit_tick) state_d = ST_START;
            ST_START: if (bit_tick) state_d = ST_DATA;
            ST_DATA:  if (bit_tick && bitcnt_q == LAST_BIT)
                          state_d = cfg.nine ? ST_NINTH : ST_STOP1;
            ST_NINTH: if (bit_tick) state_d = ST_STOP1;
            ST_STOP1: if (bit_tick) state_d = cfg.two ? ST_STOP2 : ST_IDLE;
            ST_STOP2: if (bit_tick) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        load       = (state_q == ST_IDLE) && wr_en;
        shift      = (state_q == ST_DATA) && bit_tick;
        enter_last = ((state_d == ST_STOP1) && (state_q != ST_STOP1) && !cfg.two) ||
                     ((state_d == ST_STOP2) && (state_q != ST_STOP2));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt_q <= '0;
            done_q   <= 1'b0;
        end else begin
            if (state_q == ST_START) bitcnt_q <= '0;
            else if (shift)          bitcnt_q <= bitcnt_q + 1'b1;
            if (enter_last)          done_q <= 1'b1;
            else if (done_clr)       done_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        busy = (state_q != ST_IDLE);
        done = done_q;
        unique case (state_q)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = lsb;
            ST_NINTH: txd = cfg.bit9;
            default:  txd = 1'b1;
        endcase
    end

    // R1: line is high whenever no frame is in progress
    assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // R2: the line only drops inside a frame
    assert_low_only_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txd) |-> busy);

    // R8: done rises only in a stop bit of a running frame
    assert_done_in_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (busy && txd));

endmodule

// File: rtl/sbuf_uart_tx.sv
module sbuf_uart_tx
    import sbtx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int FIX_LOG2 = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              baud_tick,
    input  logic [1:0]        mode,
    input  logic              bit9_in,
    input  logic              two_stop,
    input  logic              fix_div64,
    input  logic              done_clr,
    output logic              txd,
    output logic              busy,
    output logic              done
);
    frame_cfg_t cfg_q;
    logic       load;
    logic       shift;
    logic       bit_tick;
    logic       lsb;

    // frame settings captured at the accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q.nine  <= (tx_mode_e'(mode) != MD_8VAR);
            cfg_q.fixed <= (tx_mode_e'(mode) == MD_9FIX);
            cfg_q.two   <= two_stop;
            cfg_q.bit9  <= bit9_in;
            cfg_q.slow  <= fix_div64;
        end
    end

    sbtx_rate #(.FIX_LOG2(FIX_LOG2)) u_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .use_fixed (cfg_q.fixed),
        .slow      (cfg_q.slow),
        .ext_tick  (baud_tick),
        .bit_tick  (bit_tick)
    );

    sbtx_shreg #(.DATA_W(DATA_W)) u_shreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .shift (shift),
        .din   (wr_data),
        .lsb   (lsb)
    );

    sbtx_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .bit_tick (bit_tick),
        .cfg      (cfg_q),
        .lsb      (lsb),
        .done_clr (done_clr),
        .load     (load),
        .shift    (shift),
        .txd      (txd),
        .busy     (busy),
        .done     (done)
    );

    // R9: a write during a frame does not end or restart it
    assert_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && !bit_tick) |=> busy);

endmodule

// File: tb/sim_sbuf_uart_tx.sv
module sim_sbuf_uart_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       baud_tick = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       bit9_in = 1'b0;
    logic       two_stop = 1'b0;
    logic       fix_div64 = 1'b0;
    logic       done_clr = 1'b0;
    logic       txd, busy, done;

    always #2 clk = ~clk;

    sbuf_uart_tx u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .baud_tick(baud_tick), .mode(mode), .bit9_in(bit9_in),
        .two_stop(two_stop), .fix_div64(fix_div64), .done_clr(done_clr),
        .txd(txd), .busy(busy), .done(done)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string cur_req = "R1";

    // external tick generator: period 0 means no ticks
    int tick_per = 5;
    int tick_cnt = 0;
    always @(negedge clk) begin
        if (tick_per > 0) begin
            tick_cnt = tick_cnt + 1;
            if (tick_cnt >= tick_per) begin
                tick_cnt = 0;
                baud_tick <= 1'b1;
            end else begin
                baud_tick <= 1'b0;
            end
        end else begin
            baud_tick <= 1'b0;
        end
    end

    // behavioural reference model
    logic m_bits [0:11];
    int   m_len, m_idx, m_cnt;
    logic m_busy, m_done, m_fixed, m_slow;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_idx = -1; m_len = 0; m_cnt = 0;
            m_fixed = 0; m_slow = 0;
        end else begin
            int  dv;
            logic t, setd;
            setd = 0;
            dv = m_slow ? 64 : 32;
            t = m_fixed ? ((m_cnt % dv) == dv - 1) : baud_tick;
            m_cnt = m_cnt + 1;
            if (!m_busy) begin
                if (wr_en) begin
                    int k;
                    m_bits[0] = 1'b0;
                    for (int i = 0; i < 8; i++) m_bits[1 + i] = wr_data[i];
                    k = 9;
                    if (mode != 2'b00) begin m_bits[k] = bit9_in; k = k + 1; end
                    m_bits[k] = 1'b1; k = k + 1;
                    if (two_stop) begin m_bits[k] = 1'b1; k = k + 1; end
                    m_len = k; m_idx = -1; m_busy = 1;
                    m_fixed = (mode == 2'b01); m_slow = fix_div64;
                end
            end else if (t) begin
                m_idx = m_idx + 1;
                if (m_idx == m_len) m_busy = 0;
                else if (m_idx == m_len - 1) setd = 1;
            end
            if (setd) m_done = 1;
            else if (done_clr) m_done = 0;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic ex_txd;
            ex_txd = (m_busy && m_idx >= 0) ? m_bits[m_idx] : 1'b1;
            n_cmp = n_cmp + 3;
            if (txd !== ex_txd) begin
                n_bad++;
                $display("FAIL %s txd cyc=%0d got %b exp %b", cur_req, cyc, txd, ex_txd);
            end
            if (busy !== m_busy) begin
                n_bad++;
                $display("FAIL %s busy cyc=%0d got %b exp %b", cur_req, cyc, busy, m_busy);
            end
            if (done !== m_done) begin
                n_bad++;
                $display("FAIL %s done cyc=%0d got %b exp %b", cur_req, cyc, done, m_done);
            end
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send(logic [7:0] d, logic [1:0] md, logic b9, logic ts, logic d64);
        wr_data = d; mode = md; bit9_in = b9; two_stop = ts; fix_div64 = d64;
        wr_en = 1'b1;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic finish_frame();
        while (busy) step(1);
        step(2);
        done_clr = 1'b1;
        step(1);
        done_clr = 1'b0;
        step(1);
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired got %0d cycles exp below 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        // R1: reset state, idle
        cur_req = "R1";
        n_cmp++;
        if (txd !== 1'b1 || busy !== 1'b0 || done !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset got %b%b%b exp 100", txd, busy, done);
        end
        step(10);

        // R2 and R3: 8-bit frame, one stop bit
        cur_req = "R2_R3";
        send(8'hA5, 2'b00, 1'b0, 1'b0, 1'b0);
        finish_frame();
        send(8'h00, 2'b00, 1'b1, 1'b0, 1'b0);
        finish_frame();
        send(8'hF0, 2'b00, 1'b0, 1'b0, 1'b0);
        finish_frame();

        // R4 and R5: ninth bit and two stop bits
        cur_req = "R4_R5";
        send(8'h3C, 2'b10, 1'b1, 1'b1, 1'b0);
        finish_frame();
        send(8'hFF, 2'b11, 1'b0, 1'b0, 1'b0);
        finish_frame();
        send(8'h81, 2'b10, 1'b0, 1'b1, 1'b0);
        finish_frame();

        // R6: fixed rate, external ticks ignored
        cur_req = "R6";
        tick_per = 3;
        send(8'h5A, 2'b01, 1'b1, 1'b0, 1'b0);
        finish_frame();
        send(8'hC3, 2'b01, 1'b0, 1'b1, 1'b1);
        finish_frame();

        // R7: irregular external ticks
        cur_req = "R7";
        tick_per = 7;
        send(8'h69, 2'b11, 1'b1, 1'b0, 1'b0);
        step(20);
        tick_per = 2;
        finish_frame();
        tick_per = 5;

        // R9: writes during a frame are ignored
        cur_req = "R9";
        send(8'h96, 2'b00, 1'b0, 1'b0, 1'b0);
        step(4);
        send(8'h00, 2'b10, 1'b1, 1'b1, 1'b0);
        step(13);
        send(8'hFF, 2'b00, 1'b0, 1'b0, 1'b0);
        finish_frame();

        // R10: setting changes during a frame have no effect
        cur_req = "R10";
        send(8'h4B, 2'b10, 1'b0, 1'b0, 1'b0);
        mode = 2'b01; bit9_in = 1'b1; two_stop = 1'b1; fix_div64 = 1'b1;
        finish_frame();

        // R8: done_clr held through the end of a frame; set wins
        cur_req = "R8";
        send(8'h12, 2'b00, 1'b0, 1'b1, 1'b0);
        done_clr = 1'b1;
        while (busy) step(1);
        done_clr = 1'b0;
        step(2);
        send(8'h34, 2'b00, 1'b0, 1'b0, 1'b0);
        while (busy) step(1);
        step(5);
        n_cmp++;
        if (done !== 1'b1) begin
            n_bad++;
            $display("FAIL R8 sticky done got %b exp 1", done);
        end
        done_clr = 1'b1;
        step(1);
        done_clr = 1'b0;
        step(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule